// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Guarded Writes

This block is a watchdog timer that counts down in two chained stages. When the first stage runs out, it sets an interrupt status bit and can raise an interrupt. The second stage is then loaded and starts counting. If it also runs out, the block records a sticky timeout flag and, when reboot is enabled, pulses a reset request. Software keeps the system alive by restarting the count before the first stage expires.

The preload and restart registers are guarded against stray writes. A two-byte key must first be written to the restart register, and that key allows exactly one guarded write. A lock bit keeps the timer running until the next block reset. The countdown tick comes from a free-running prescaler on the bus clock. A configuration bit chooses between a slow tick and a fast tick.

Register offsets (byte address, word aligned): 0x00 stage-1 preload, 0x04 stage-2 preload, 0x08 interrupt status, 0x0C restart/key, 0x10 configuration, 0x14 control, 0x18 live count.

Top module: `wdog2`

## Requirements
- R1: Writing byte 0x80 and then byte 0x86 (wdata bits 7:0) to offset 0x0C arms the guard. The armed guard accepts exactly one write to a guarded register (0x00, 0x04 or 0x0C) and is then disarmed.
- R2: A write to a guarded register while the guard is not armed is ignored. Any guarded write between the 0x80 and 0x86 bytes other than 0x86 to offset 0x0C aborts the sequence, which must then start again with 0x80.
- R3: An armed write to 0x0C with bit 8 set is a restart. It returns the block to stage 1, loads the count from the stage-1 preload and restarts the prescaler, so no expiry happens for a full stage-1 period counted from that write.
- R4: Stage 1 expires on the (P1+1)th tick after enable or restart. Expiry sets status bit 0 of offset 0x08, which is cleared by writing 1 to that bit. The irq output follows that bit when config bits 1:0 are nonzero and the timer is enabled.
- R5: When stage 1 expires, stage 2 is loaded with P2 and expires P2+1 ticks later. In watchdog mode with config bit 5 set, stage-2 expiry drives rst_req high for exactly PULSE_LEN clocks.
- R6: A tick occurs every 2^SLOW_BITS clocks, or every 2^FAST_BITS clocks when config bit 2 is set. The first tick comes one full tick period after enable or restart.
- R7: The control register at 0x14 holds a lock bit (bit 0), an enable bit (bit 1) and a free-running mode bit (bit 2). Once the lock bit is set, the enable bit cannot be cleared and the mode bit cannot change until rst_n is asserted.
- R8: In free-running mode (control bit 2 set), stage-2 expiry restarts stage 1 without a reset request and without setting the timeout flag.
- R9: While the enable bit is clear, the live count at 0x18 holds the stage-1 preload, and irq and rst_req stay low.
- R10: In watchdog mode, stage-2 expiry sets the timeout flag at bit 9 of offset 0x0C, whether or not reboot is enabled. The flag survives rst_n. It is cleared only by por_n or by an armed write to 0x0C with bit 9 set.
- R11: After reset, both preloads read 0xFFFFF, and the control, config, status and flag bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; clears the timeout flag |
| rst_n | input | 1 | Block reset, active low; clears everything except the flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Stage-1 interrupt |
| rst_req | output | 1 | Reset request pulse on stage-2 expiry |

## Verification
The assertions take for granted that writes arrive as one-cycle strobes with a stable address. They also assume that FAST_BITS does not exceed SLOW_BITS, and that nothing changes the configuration while a countdown is being measured.

The stimulus respects these assumptions. Every timed scenario starts by disabling the timer, then loads the preloads through the guard, clears the status, and only then enables. Random preloads stay small, so both stages fit in a short window. The bench predicts the expiry cycles with its own tick arithmetic.

// File: rtl/wdog2.sv
module wdog2 #(
  parameter int CNT_W     = 20,
  parameter int SLOW_BITS = 15,
  parameter int FAST_BITS = 5,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [1:0] U_IDLE = 2'd0, U_GOT = 2'd1, U_ARM = 2'd2;

  logic [CNT_W-1:0]     pre1, pre2, cnt;
  logic [SLOW_BITS-1:0] presc;
  logic [1:0]           ust, cfg_itype;
  logic                 cfg_fast, cfg_reboot;
  logic                 lock, en, mode_free, stage, int_sts, tflag;
  logic [PW-1:0]        pulse;

  wire sel_pre1 = wr_en && addr[4:2] == 3'd0;
  wire sel_pre2 = wr_en && addr[4:2] == 3'd1;
  wire sel_sts  = wr_en && addr[4:2] == 3'd2;
  wire sel_rld  = wr_en && addr[4:2] == 3'd3;
  wire sel_cfg  = wr_en && addr[4:2] == 3'd4;
  wire sel_ctl  = wr_en && addr[4:2] == 3'd5;
  wire prot_wr  = sel_pre1 || sel_pre2 || sel_rld;
  wire armed    = ust == U_ARM;
  wire rld_ev   = armed && sel_rld && wdata[8];
  wire clr_flag = armed && sel_rld && wdata[9];
  wire tick     = en && (cfg_fast ? &presc[FAST_BITS-1:0] : &presc);
  wire at_zero  = tick && !rld_ev && cnt == '0;
  wire exp1     = at_zero && !stage;
  wire exp2     = at_zero && stage;

  logic unused_bits;
  assign unused_bits = ^{wdata[31:CNT_W], addr[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ust <= U_IDLE;
    else if (prot_wr)
      case (ust)
        U_IDLE:  ust <= (sel_rld && wdata[7:0] == 8'h80) ? U_GOT : U_IDLE;
        U_GOT:   ust <= (sel_rld && wdata[7:0] == 8'h86) ? U_ARM : U_IDLE;
        default: ust <= U_IDLE;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre1 <= '1;
      pre2 <= '1;
    end else begin
      if (armed && sel_pre1) pre1 <= wdata[CNT_W-1:0];
      if (armed && sel_pre2) pre2 <= wdata[CNT_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_itype <= '0; cfg_fast <= 1'b0; cfg_reboot <= 1'b0;
      lock <= 1'b0; en <= 1'b0; mode_free <= 1'b0;
    end else begin
      if (sel_cfg) begin
        cfg_itype  <= wdata[1:0];
        cfg_fast   <= wdata[2];
        cfg_reboot <= wdata[5];
      end
      if (sel_ctl) begin
        lock      <= lock | wdata[0];
        en        <= wdata[1] | (lock & en);
        mode_free <= lock ? mode_free : wdata[2];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      presc <= '0; cnt <= '1; stage <= 1'b0;
    end else if (!en || rld_ev) begin
      presc <= '0; cnt <= pre1; stage <= 1'b0;
    end else begin
      presc <= presc + 1'b1;
      if (tick) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!stage) begin stage <= 1'b1; cnt <= pre2; end
        else begin stage <= 1'b0; cnt <= pre1; end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) int_sts <= 1'b0;
    else if (exp1) int_sts <= 1'b1;
    else if (sel_sts && wdata[0]) int_sts <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pulse <= '0;
    else if (!en) pulse <= '0;
    else if (exp2 && !mode_free && cfg_reboot) pulse <= PW'(PULSE_LEN);
    else if (pulse != '0) pulse <= pulse - 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) tflag <= 1'b0;
    else if (exp2 && !mode_free) tflag <= 1'b1;
    else if (clr_flag) tflag <= 1'b0;

  assign irq     = en && int_sts && cfg_itype != 2'd0;
  assign rst_req = pulse != '0;

  always_comb begin
    rdata = '0;
    case (addr[4:2])
      3'd0: rdata[CNT_W-1:0] = pre1;
      3'd1: rdata[CNT_W-1:0] = pre2;
      3'd2: rdata[0] = int_sts;
      3'd3: rdata[9] = tflag;
      3'd4: rdata[5:0] = {cfg_reboot, 2'b00, cfg_fast, cfg_itype};
      3'd5: rdata[2:0] = {mode_free, en, lock};
      3'd6: rdata[CNT_W-1:0] = cnt;
      default: rdata = '0;
    endcase
  end

  assert_arm_after_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ust == U_ARM |-> ($past(ust) == U_GOT || $past(ust) == U_ARM));

  assert_irq_on_stage2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_sts) |-> stage);

  assert_req_needs_reboot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(cfg_reboot) && !$past(mode_free)));

  assert_lock_keeps_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && en) |=> en);

  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rst_req);
endmodule

// File: tb/wdog2_tb.sv
module wdog2_tb;
  localparam int SB = 3, FB = 1, PL = 3;
  logic clk = 0, por_n = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  logic irq, rst_req;
  int nchk = 0, nerr = 0;
  bit done = 0;

  wdog2 #(.CNT_W(20), .SLOW_BITS(SB), .FAST_BITS(FB), .PULSE_LEN(PL)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  always #4 clk = ~clk;

  function automatic int n_stage1(int p1, int tb);
    return (p1 + 1) << tb;
  endfunction
  function automatic int n_stage2(int p1, int p2, int tb);
    return (p1 + p2 + 2) << tb;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask
  task automatic pwr(input logic [4:0] a, input logic [31:0] d);
    wreg(5'h0C, 32'h80); wreg(5'h0C, 32'h86); wreg(a, d);
  endtask
  task automatic rreg(input logic [4:0] a, output logic [31:0] r);
    addr = a; #1; r = rdata;
  endtask

  task automatic run(input int p1, input int p2, input bit fast, input int ity,
                     input bit reboot, input bit freerun);
    int tb, n1, n2;
    bit req;
    tb = fast ? FB : SB;
    n1 = n_stage1(p1, tb);
    n2 = n_stage2(p1, p2, tb);
    req = reboot && !freerun;
    wreg(5'h14, 0);
    pwr(5'h00, p1); pwr(5'h04, p2); pwr(5'h0C, 32'h200);
    wreg(5'h10, {26'd0, reboot, 2'b00, fast, ity[1:0]});
    wreg(5'h08, 1);
    wreg(5'h14, {29'd0, freerun, 2'b10});
    repeat (n1 - 1) @(negedge clk);
    chk("R6 irq before stage-1 tick", irq, 0);
    @(negedge clk);
    chk("R4 irq at stage-1 expiry", irq, ity != 0);
    rreg(5'h08, v); chk("R4 status bit", v, 1);
    repeat (n2 - n1 - 1) @(negedge clk);
    chk("R5 rst_req before stage-2 expiry", rst_req, 0);
    @(negedge clk);
    chk(freerun ? "R8 no request in free mode" : "R5 rst_req start", rst_req, req);
    repeat (PL - 1) @(negedge clk);
    chk("R5 rst_req last pulse cycle", rst_req, req);
    @(negedge clk);
    chk("R5 rst_req pulse end", rst_req, 0);
    rreg(5'h0C, v);
    chk(freerun ? "R8 flag untouched" : "R10 flag set", v[9], !freerun);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    rreg(5'h00, v); chk("R11 stage-1 preload reset", v, 32'hFFFFF);
    rreg(5'h04, v); chk("R11 stage-2 preload reset", v, 32'hFFFFF);
    rreg(5'h14, v); chk("R11 control reset", v, 0);
    rreg(5'h0C, v); chk("R11 flag reset", v, 0);
    chk("R11 irq reset", irq, 0);
    chk("R11 rst_req reset", rst_req, 0);

    wreg(5'h00, 32'h5);
    rreg(5'h00, v); chk("R2 write without key ignored", v, 32'hFFFFF);
    pwr(5'h00, 32'h5);
    rreg(5'h00, v); chk("R1 keyed write accepted", v, 32'h5);
    wreg(5'h00, 32'h7);
    rreg(5'h00, v); chk("R1 only one write per key", v, 32'h5);
    wreg(5'h0C, 32'h80); wreg(5'h0C, 32'h55); wreg(5'h0C, 32'h86); wreg(5'h00, 32'h9);
    rreg(5'h00, v); chk("R2 aborted key", v, 32'h5);

    repeat (40) @(negedge clk);
    rreg(5'h18, v); chk("R9 count holds preload", v, 32'h5);
    chk("R9 irq low while disabled", irq, 0);
    chk("R9 rst_req low while disabled", rst_req, 0);

    // R3: restart part way through stage 1
    pwr(5'h00, 3); pwr(5'h04, 20);
    wreg(5'h10, 32'h1); wreg(5'h08, 1);
    wreg(5'h14, 32'h2);
    repeat (19) @(negedge clk);
    pwr(5'h0C, 32'h100);
    repeat (n_stage1(3, SB) - 1) @(negedge clk);
    chk("R3 restart prevents expiry", irq, 0);
    @(negedge clk);
    chk("R3 expiry counted from restart", irq, 1);
    wreg(5'h08, 1);
    chk("R4 status write-1-to-clear", irq, 0);

    for (int i = 0; i < 10; i++)
      run($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 1),
          $urandom_range(0, 3), $urandom_range(0, 1), 0);
    run(1, 1, 1, 1, 1, 1);
    run(0, 2, 0, 0, 0, 0);

    // R7 lock, R10 flag survives block reset
    wreg(5'h14, 32'h3);
    wreg(5'h14, 32'h0);
    rreg(5'h14, v); chk("R7 enable kept by lock", v, 3);
    wreg(5'h14, 32'h4);
    rreg(5'h14, v); chk("R7 mode frozen by lock", v, 3);
    rst_n = 0; @(negedge clk); rst_n = 1;
    rreg(5'h14, v); chk("R7 block reset clears lock", v, 0);
    rreg(5'h0C, v); chk("R10 flag survives rst_n", v[9], 1);
    wreg(5'h0C, 32'h200);
    rreg(5'h0C, v); chk("R10 clear without key ignored", v[9], 1);
    pwr(5'h0C, 32'h200);
    rreg(5'h0C, v); chk("R10 keyed clear", v[9], 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule